// File: doc/BRIEF.md
# 100BASE-TX Serial Stream Scrambler and Descrambler

This block applies and removes the stream cipher used on a 100 Mb/s twisted-pair link. It works one code bit at a time. On the transmit side, every plain NRZ code bit is XORed with a key bit drawn from an 11-stage linear feedback shift register. The receive side has no seed to share with the far end, so it rebuilds the same key stream from the line itself.

The receive side relies on the idle line state, which is all ones in plain text. While it is hunting, the descrambler shifts the inverted received cipher bits into its own register. It also counts how many received bits in a row agree with the bit its register predicts. When enough of those bits arrive while the signal-detect input is high, it declares lock and lets its register run free.

A lock timer guards against silent loss of alignment. Each run of idle ones in the recovered stream restarts it. If it expires, lock is dropped and the hunt begins again. A test control shortens the timer, and a bypass control passes bits straight through in both directions. All state moves only on clock edges where the bit-rate enable is high, except that losing signal detect clears lock at once.

Top module: `fx_stream_cipher`

## Requirements
- R1: After reset, `tx_cipher`, `rx_plain` and `rx_locked` are 0, and the transmit key register holds all ones.
- R2: On each edge with `bit_en` high, the transmit key bit is k = s[10] XOR s[8], where s[0] is the newest stage. The register shifts to {s[9:0], k}, and `tx_cipher` takes `tx_plain` XOR k. `tx_cipher` is registered and valid after that edge.
- R3: The transmit key register never holds all zeros. With plain input held at 0, any 2047 consecutive key bits contain exactly 1024 ones.
- R4: While `bit_en` is low, no output changes and no key register advances.
- R5: With `sig_det` high and idle (all-ones plain) cipher arriving, `rx_locked` stays 0 for at least the first 59 bits. It is 1 no later than the 71st bit, because 60 consecutive matching bits are needed after at most 11 bits of loading.
- R6: While locked, `rx_plain` equals the received cipher bit XOR the regenerated key bit. It is registered on the same `bit_en` edge.
- R7: While locked, one inverted cipher bit yields exactly one wrong `rx_plain` bit, at the same position.
- R8: `sig_det` low clears `rx_locked` at the next clock edge, whether or not `bit_en` is high, and acquisition restarts from zero.
- R9: While locked, the lock timer counts bit times. When the count reaches its limit with no restart, lock drops. The limit is 260 bit times when `test_mode` is 1 and 131072 when it is 0. After 259 bits of all-zero plain text lock still holds in test mode, and after the 260th it is gone.
- R10: Each recovered plain bit that completes a run of at least 29 consecutive ones restarts the lock timer, so an idle stream keeps lock indefinitely.
- R11: With `bypass` high, `tx_cipher` takes `tx_plain` and `rx_plain` takes `rx_cipher` on each enabled edge. Both key registers keep advancing as they would otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One-cycle strobe per code bit |
| bypass | input | 1 | Pass bits through with no cipher |
| test_mode | input | 1 | Selects the short lock timeout |
| tx_plain | input | 1 | Plain code bit to transmit |
| tx_cipher | output | 1 | Scrambled code bit |
| sig_det | input | 1 | Receive signal present |
| rx_cipher | input | 1 | Received scrambled code bit |
| rx_plain | output | 1 | Recovered plain code bit |
| rx_locked | output | 1 | Descrambler synchronized |

## Verification
The timer assertions assume that `test_mode` is changed only while the descrambler is unlocked. The bench respects this by dropping `sig_det` before every mode change. The acquisition property assumes the plain text during the hunt is idle. The receive stream in the bench comes from its own key model, started from an unrelated seed, so lock is shown for an arbitrary phase. The hold properties assume `bit_en` may stay low for any number of cycles, and the bench inserts such gaps on purpose.

// File: rtl/fxs_pkg.sv
// Shared key-register type and the x^11 + x^9 + 1 step functions.
package fxs_pkg;
    localparam int KEY_W = 11;
    typedef logic [KEY_W-1:0] key_t;

    // Key bit taken from the 11th and 9th previous bits.
    function automatic logic key_bit(input key_t s);
        return s[KEY_W-1] ^ s[KEY_W-3];
    endfunction

    // Shift one new bit into the newest stage.
    function automatic key_t key_shift(input key_t s, input logic b);
        return {s[KEY_W-2:0], b};
    endfunction
endpackage

// File: rtl/fxs_scrambler.sv
// Transmit scrambler: XORs each plain bit with the LFSR key bit.
// Assumes bit_en is a strobe; the register is seeded with all ones.
module fxs_scrambler
    import fxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bypass,
    input  logic plain,
    output logic cipher
);
    key_t st;
    logic kb;

    // Current key bit.
    assign kb = key_bit(st);

    // Advance the key register and register the cipher bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= '1;
            cipher <= 1'b0;
        end else if (bit_en) begin
            st     <= key_shift(st, kb);
            cipher <= bypass ? plain : (plain ^ kb);
        end
    end

    p_seed_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st != '0);
    p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(cipher));
    p_tx_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && bypass |=> cipher == $past(plain));
endmodule

// File: rtl/fxs_descrambler.sv
// Receive descrambler: loads the inverted cipher while hunting, counts
// matching predicted bits, locks after ACQ_BITS of them, then free-runs.
// Assumes the far end sends idle (all ones) plain text during the hunt.
module fxs_descrambler
    import fxs_pkg::*;
#(
    parameter int ACQ_BITS = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bypass,
    input  logic sig_det,
    input  logic cipher,
    input  logic expire,
    output logic plain_now,
    output logic plain_out,
    output logic locked
);
    localparam int CW = $clog2(ACQ_BITS + 1);

    key_t          st;
    logic [CW-1:0] good;
    logic          pred;
    logic          match;

    // Predicted key bit, idle match test and unregistered plain bit.
    assign pred      = key_bit(st);
    assign match     = (~cipher) == pred;
    assign plain_now = cipher ^ pred;

    // Key register, run-of-matches counter, lock flag and output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= '0;
            good      <= '0;
            locked    <= 1'b0;
            plain_out <= 1'b0;
        end else begin
            if (bit_en) begin
                plain_out <= bypass ? cipher : plain_now;
                if (locked) begin
                    st <= key_shift(st, pred);
                end else begin
                    st <= key_shift(st, ~cipher);
                    if (sig_det && match) begin
                        if (good == CW'(ACQ_BITS - 1)) begin
                            locked <= 1'b1;
                            good   <= '0;
                        end else begin
                            good <= good + 1'b1;
                        end
                    end else begin
                        good <= '0;
                    end
                end
            end
            if (!sig_det || expire) begin
                locked <= 1'b0;
                good   <= '0;
            end
        end
    end

    p_sd_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_det |=> !locked);
    p_acq_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(good) == CW'(ACQ_BITS - 1) && $past(sig_det));
    p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(plain_out));
    p_rx_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && bypass |=> plain_out == $past(cipher));
endmodule

// File: rtl/fxs_lock_timer.sv
// Lock timer: counts bit times while locked, restarted by runs of idle ones
// in the recovered stream; raises expire on the bit that reaches the limit.
// Assumes test_mode is steady while locked.
module fxs_lock_timer #(
    parameter int IDLE_RUN  = 29,
    parameter int TMO_LONG  = 131072,
    parameter int TMO_SHORT = 260
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic test_mode,
    input  logic locked,
    input  logic plain_bit,
    output logic expire
);
    localparam int TMO_MAX = (TMO_LONG > TMO_SHORT) ? TMO_LONG : TMO_SHORT;
    localparam int TW      = $clog2(TMO_MAX + 1);
    localparam int RW      = $clog2(IDLE_RUN + 1);

    logic [RW-1:0] run;
    logic [TW-1:0] tmr;
    logic [TW-1:0] limit;
    logic          restart;

    // Timeout limit and restart on a completed idle run.
    assign limit   = test_mode ? TW'(TMO_SHORT) : TW'(TMO_LONG);
    assign restart = plain_bit && (run >= RW'(IDLE_RUN - 1));
    assign expire  = locked && bit_en && !restart && (tmr >= limit - 1'b1);

    // Count consecutive ones in the recovered stream, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else if (bit_en) begin
            if (!plain_bit)
                run <= '0;
            else if (run != RW'(IDLE_RUN))
                run <= run + 1'b1;
        end
    end

    // Bit-time counter, held at zero while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n || !locked) begin
            tmr <= '0;
        end else if (bit_en) begin
            tmr <= restart ? '0 : tmr + 1'b1;
        end
    end

    p_tmr_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> tmr < limit);
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        locked && bit_en && restart |=> tmr == '0);
endmodule

// File: rtl/fx_stream_cipher.sv
// Top: transmit scrambler plus receive descrambler with lock timer.
// Assumes one bit per bit_en strobe on both sides.
module fx_stream_cipher #(
    parameter int ACQ_BITS  = 60,
    parameter int IDLE_RUN  = 29,
    parameter int TMO_LONG  = 131072,
    parameter int TMO_SHORT = 260
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bypass,
    input  logic test_mode,
    input  logic tx_plain,
    output logic tx_cipher,
    input  logic sig_det,
    input  logic rx_cipher,
    output logic rx_plain,
    output logic rx_locked
);
    logic expire;
    logic plain_now;

    fxs_scrambler u_scr (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .bypass (bypass),
        .plain  (tx_plain),
        .cipher (tx_cipher)
    );

    fxs_descrambler #(.ACQ_BITS(ACQ_BITS)) u_dsc (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bypass    (bypass),
        .sig_det   (sig_det),
        .cipher    (rx_cipher),
        .expire    (expire),
        .plain_now (plain_now),
        .plain_out (rx_plain),
        .locked    (rx_locked)
    );

    fxs_lock_timer #(
        .IDLE_RUN  (IDLE_RUN),
        .TMO_LONG  (TMO_LONG),
        .TMO_SHORT (TMO_SHORT)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .test_mode (test_mode),
        .locked    (rx_locked),
        .plain_bit (plain_now),
        .expire    (expire)
    );
endmodule

// File: tb/tb_fx_stream_cipher.sv
module tb_fx_stream_cipher;
    localparam int CLK_T = 10;

    logic clk = 1'b0;
    logic rst_n, bit_en, bypass, test_mode, tx_plain, sig_det, rx_cipher;
    logic tx_cipher, rx_plain, rx_locked;
    logic [10:0] ts, rs;
    int checks = 0, errors = 0;

    always #(CLK_T/2) clk = ~clk;

    fx_stream_cipher dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bypass(bypass),
        .test_mode(test_mode), .tx_plain(tx_plain), .tx_cipher(tx_cipher),
        .sig_det(sig_det), .rx_cipher(rx_cipher), .rx_plain(rx_plain),
        .rx_locked(rx_locked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Next key bit of a model register, advancing it.
    function automatic logic nk(inout logic [10:0] s);
        logic k;
        k = s[10] ^ s[8];
        s = {s[9:0], k};
        return k;
    endfunction

    task automatic step(input logic tp, input logic rc);
        tx_plain = tp; rx_cipher = rc; bit_en = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    // Send one receive-side plain bit through the bench key model.
    task automatic rx_send(input logic p, input logic flip);
        logic k;
        k = nk(rs);
        step(1'b0, p ^ k ^ flip);
    endtask

    task automatic relock(input string req);
        int n;
        n = 0;
        while (!rx_locked && n < 80) begin rx_send(1'b1, 1'b0); n++; end
        check(rx_locked && n >= 60 && n <= 71, req, n, 71);
    endtask

    initial begin
        #(CLK_T * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; bit_en = 0; bypass = 0; test_mode = 0;
        tx_plain = 0; sig_det = 0; rx_cipher = 0;
        ts = '1; rs = 11'h2C5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(tx_cipher == 0 && rx_plain == 0 && rx_locked == 0, "R1", {tx_cipher, rx_plain, rx_locked}, 0);
        rst_n = 1;

        // R2 cipher equals plain xor key, several patterns
        for (int i = 0; i < 300; i++) begin
            logic p, k;
            p = (i < 100) ? 1'b1 : (i < 200) ? (i % 3 == 0) : ((i * 7) % 5 < 2);
            k = nk(ts);
            step(p, 1'b0);
            check(tx_cipher == (p ^ k), "R2", tx_cipher, p ^ k);
        end

        // R3 full period of key stream has 1024 ones
        begin
            int ones;
            ones = 0;
            for (int i = 0; i < 2047; i++) begin
                void'(nk(ts));
                step(1'b0, 1'b0);
                ones += tx_cipher;
            end
            check(ones == 1024, "R3", ones, 1024);
        end

        // R4 no advance with bit_en low
        begin
            logic held, k;
            held = tx_cipher;
            bit_en = 0; tx_plain = ~tx_plain; rx_cipher = 1;
            repeat (5) @(posedge clk);
            @(negedge clk);
            check(tx_cipher == held, "R4", tx_cipher, held);
            k = nk(ts);
            step(1'b1, 1'b0);
            check(tx_cipher == (1'b1 ^ k), "R4", tx_cipher, 1'b1 ^ k);
        end

        // R11 transmit bypass, key keeps advancing
        bypass = 1;
        for (int i = 0; i < 20; i++) begin
            void'(nk(ts));
            step(i[0], 1'b0);
            check(tx_cipher == i[0], "R11", tx_cipher, i[0]);
        end
        bypass = 0;
        begin
            logic k;
            k = nk(ts);
            step(1'b0, 1'b0);
            check(tx_cipher == k, "R11", tx_cipher, k);
        end

        // R5 acquisition on idle
        sig_det = 1;
        for (int i = 0; i < 59; i++) rx_send(1'b1, 1'b0);
        check(rx_locked == 0, "R5", rx_locked, 0);
        for (int i = 0; i < 12; i++) rx_send(1'b1, 1'b0);
        check(rx_locked == 1, "R5", rx_locked, 1);

        // R6 recovered plain under mixed patterns
        for (int i = 0; i < 120; i++) begin
            logic p;
            p = (i % 40 < 30) ? 1'b1 : ((i * 5) % 3 == 0);
            rx_send(p, 1'b0);
            check(rx_plain == p, "R6", rx_plain, p);
        end

        // R7 single cipher error gives single plain error
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 30; i++) begin
                logic p;
                p = (i % 4 != 0);
                rx_send(p, i == 10);
                if (rx_plain != p) bad++;
                if (i == 10) check(rx_plain == !p, "R7", rx_plain, !p);
            end
            check(bad == 1, "R7", bad, 1);
        end

        // R8 signal loss clears lock without bit_en
        bit_en = 0; sig_det = 0;
        @(posedge clk); @(negedge clk);
        check(rx_locked == 0, "R8", rx_locked, 0);

        // R10 idle keeps lock in test mode
        test_mode = 1; sig_det = 1;
        relock("R5");
        for (int i = 0; i < 600; i++) rx_send(1'b1, 1'b0);
        check(rx_locked == 1, "R10", rx_locked, 1);

        // R9 short timeout on all-zero plain
        for (int i = 0; i < 259; i++) rx_send(1'b0, 1'b0);
        check(rx_locked == 1, "R9", rx_locked, 1);
        rx_send(1'b0, 1'b0);
        check(rx_locked == 0, "R9", rx_locked, 0);
        relock("R5");

        // R9 normal limit outlasts the short one
        sig_det = 0; bit_en = 0;
        @(posedge clk); @(negedge clk);
        test_mode = 0; sig_det = 1;
        relock("R5");
        for (int i = 0; i < 400; i++) rx_send(1'b0, 1'b0);
        check(rx_locked == 1, "R9", rx_locked, 1);

        // R11 receive bypass
        bypass = 1;
        for (int i = 0; i < 10; i++) begin
            void'(nk(rs));
            step(1'b0, i[1]);
            check(rx_plain == i[1], "R11", rx_plain, i[1]);
        end
        bypass = 0;
        for (int i = 0; i < 5; i++) begin
            rx_send(1'b0, 1'b0);
            check(rx_plain == 0, "R11", rx_plain, 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule